// File: doc/BRIEF.md
# Shift-and-Add Vector Magnitude Estimator

This block estimates the length of a two-component vector, sqrt(a² + b²), for two signed 16-bit operands. It needs no multiplier and no root extractor. It takes the absolute values of both operands and sorts them into a larger magnitude x and a smaller magnitude y. It then forms x − x/8 + y/2, and the result is the greater of that sum and x.

The work runs as a fixed sequence of seven controller states over a small pool of shared arithmetic:

- two absolute-value units;
- one compare unit that yields either the larger or the smaller of its inputs;
- one adder/subtractor.

A single Start pulse taken in the idle state loads both operands. Some cycles later the estimate appears on the result port for exactly one cycle, marked by Done. Start is disregarded until the controller returns to idle.

Top module: `hypot_approx`

## Requirements
- R1: Synchronous reset, taking effect at a rising edge, puts the controller in idle with `done_o` = 0 and `result_o` = 0. An operation in flight is abandoned and produces no Done pulse.
- R2: Let x and y be the larger and smaller of |a| and |b|. The result is max(x − (x >> 3) + (y >> 1), x), using logical right shifts that drop fractional bits.
- R3: Magnitudes are 17-bit unsigned, so an operand of −32768 has magnitude 32768 with no wrap-around. For example, (−32768, −32768) gives 45056.
- R4: Suppose `start_i` = 1 is sampled at a rising edge while idle. Then `done_o` is 1 for exactly one cycle, beginning just after the fifth rising edge after that one.
- R5: `result_o` is 0 whenever `done_o` is 0.
- R6: `start_i` and operand changes are ignored while an operation is in progress. The result always reflects the operands sampled with the accepted Start.
- R7: After the Done cycle the controller is idle again. With `start_i` held at 1, a new operation is accepted at the seventh rising edge after the previous acceptance, so operations issue every seven cycles.
- R8: Whenever `done_o` is 1, `result_o` lies between x and x + (x >> 1) inclusive.
- R9: The result does not depend on the order of the two operands or on their signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin; taken only when idle |
| a_i | input | 16 | First signed operand |
| b_i | input | 16 | Second signed operand |
| result_o | output | 17 | Unsigned magnitude estimate, valid while `done_o` is 1 |
| done_o | output | 1 | One-cycle flag marking `result_o` valid |

## Verification
The operand patterns are chosen to reach every branch of the estimator:

- **Both operands zero**, and **one operand zero**: check the floor of the arithmetic.
- **Equal magnitudes with opposite signs**: check the absolute-value units.
- **Small values**: truncation in x/8 and y/2 matters here.
- **Swapped and negated pairs**: show that the operand sort does not depend on order.
- **Cases where y is tiny**: push the final compare toward selecting x.
- **−32768 in one or both positions**: separates a 17-bit magnitude from a wrapped 16-bit one.

Further runs change Start and the operands while an operation is in progress, hold Start high continuously, and reset in mid-operation. These confirm acceptance timing, the seven-cycle issue rate and abandonment.

// File: rtl/hyp_pkg.sv
package hyp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ABS  = 3'd1,
        ST_BIG  = 3'd2,
        ST_SUB  = 3'd3,
        ST_ADD  = 3'd4,
        ST_FIN  = 3'd5,
        ST_OUT  = 3'd6
    } hyp_state_e;

endpackage

// File: rtl/hyp_absval.sv
module hyp_absval #(
    parameter int IN_W = 16
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic        [IN_W:0]   mag_o
);
    logic signed [IN_W:0] ext_w;

    always_comb begin
        ext_w = {val_i[IN_W-1], val_i};
        mag_o = ext_w[IN_W] ? IN_W'(0) - ext_w : ext_w;
    end
endmodule

// File: rtl/hyp_maxmin.sv
module hyp_maxmin #(
    parameter int W = 17
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    input  logic         pick_max_i,
    output logic [W-1:0] y_o
);
    logic p_ge_q_w;

    always_comb begin
        p_ge_q_w = (p_i >= q_i);
        y_o      = (p_ge_q_w == pick_max_i) ? p_i : q_i;
    end
endmodule

// File: rtl/hyp_alu.sv
module hyp_alu #(
    parameter int W = 17
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        y_o = sub_i ? (p_i - q_i) : (p_i + q_i);
    end
endmodule

// File: rtl/hypot_approx.sv
module hypot_approx #(
    parameter int DATA_W    = 16,
    parameter int SHIFT_BIG = 3,
    parameter int SHIFT_SML = 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W:0]     result_o,
    output logic                done_o
);
    import hyp_pkg::*;

    localparam int MAG_W = DATA_W + 1;
    localparam int N_ABS = 2;

    typedef struct packed {
        hyp_state_e         state;
        logic [DATA_W-1:0]  a;
        logic [DATA_W-1:0]  b;
        logic [MAG_W-1:0]   t1;
        logic [MAG_W-1:0]   t2;
        logic [MAG_W-1:0]   x;
        logic [MAG_W-1:0]   y;
        logic [MAG_W-1:0]   acc;
        logic [MAG_W-1:0]   res;
        logic               done;
    } hyp_regs_t;

    hyp_regs_t r_d, r_q;

    logic [DATA_W-1:0] abs_in_w  [N_ABS];
    logic [MAG_W-1:0]  abs_out_w [N_ABS];

    logic [MAG_W-1:0]  mm_p_w, mm_q_w, mm_y_w;
    logic              mm_max_w;
    logic [MAG_W-1:0]  alu_p_w, alu_q_w, alu_y_w;
    logic              alu_sub_w;
    logic [MAG_W-1:0]  x_mag_w;

    assign abs_in_w[0] = r_q.a;
    assign abs_in_w[1] = r_q.b;

    for (genvar g = 0; g < N_ABS; g++) begin : g_abs
        hyp_absval #(.IN_W(DATA_W)) i_abs (
            .val_i (abs_in_w[g]),
            .mag_o (abs_out_w[g])
        );
    end

    hyp_maxmin #(.W(MAG_W)) i_maxmin (
        .p_i        (mm_p_w),
        .q_i        (mm_q_w),
        .pick_max_i (mm_max_w),
        .y_o        (mm_y_w)
    );

    hyp_alu #(.W(MAG_W)) i_alu (
        .p_i   (alu_p_w),
        .q_i   (alu_q_w),
        .sub_i (alu_sub_w),
        .y_o   (alu_y_w)
    );

    // Operand steering for the shared units, selected by the current state.
    always_comb begin
        mm_p_w    = r_q.t1;
        mm_q_w    = r_q.t2;
        mm_max_w  = 1'b1;
        alu_p_w   = r_q.x;
        alu_q_w   = r_q.x >> SHIFT_BIG;
        alu_sub_w = 1'b1;
        unique case (r_q.state)
            ST_SUB: mm_max_w = 1'b0;
            ST_ADD: begin
                alu_p_w   = r_q.y >> SHIFT_SML;
                alu_q_w   = r_q.acc;
                alu_sub_w = 1'b0;
            end
            ST_FIN: begin
                mm_p_w = r_q.acc;
                mm_q_w = r_q.x;
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.res  = '0;
        unique case (r_q.state)
            ST_IDLE: if (start_i) begin
                r_d.a     = a_i;
                r_d.b     = b_i;
                r_d.state = ST_ABS;
            end
            ST_ABS: begin
                r_d.t1    = abs_out_w[0];
                r_d.t2    = abs_out_w[1];
                r_d.state = ST_BIG;
            end
            ST_BIG: begin
                r_d.x     = mm_y_w;
                r_d.state = ST_SUB;
            end
            ST_SUB: begin
                r_d.y     = mm_y_w;
                r_d.acc   = alu_y_w;
                r_d.state = ST_ADD;
            end
            ST_ADD: begin
                r_d.acc   = alu_y_w;
                r_d.state = ST_FIN;
            end
            ST_FIN: begin
                r_d.res   = mm_y_w;
                r_d.done  = 1'b1;
                r_d.state = ST_OUT;
            end
            ST_OUT:  r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign x_mag_w  = r_q.x;
    assign result_o = r_q.res;
    assign done_o   = r_q.done;

endmodule

// File: rtl/hyp_checker.sv
module hyp_checker #(
    parameter int MAG_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [MAG_W-1:0] result,
    input logic [MAG_W-1:0] x_mag
);
    logic [MAG_W:0] upper_w;
    assign upper_w = {1'b0, x_mag} + {2'b0, x_mag[MAG_W-1:1]};

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

    // R4
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(start, 6));

    // R5
    a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> (result == '0));

    // R8
    a_r8_bounds: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, result} >= {1'b0, x_mag} && {1'b0, result} <= upper_w));
endmodule

bind hypot_approx hyp_checker #(.MAG_W(DATA_W + 1)) i_hyp_checker (
    .clk    (clk_i),
    .rst    (rst_i),
    .start  (start_i),
    .done   (done_o),
    .result (result_o),
    .x_mag  (x_mag_w)
);

// File: tb/test_hypot_approx.sv
module test_hypot_approx;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic signed [15:0] a = '0;
    logic signed [15:0] b = '0;
    logic [16:0]        result;
    logic               done;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    hypot_approx i_hypot_approx (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .done_o   (done)
    );

    function automatic int model(input logic signed [15:0] pa, input logic signed [15:0] pb);
        int ia = pa;
        int ib = pb;
        int ma = (ia < 0) ? -ia : ia;
        int mb = (ib < 0) ? -ib : ib;
        int x  = (ma > mb) ? ma : mb;
        int y  = (ma > mb) ? mb : ma;
        int t  = x - (x >> 3) + (y >> 1);
        return (t > x) ? t : x;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One operation; after the accepting edge, sample at each falling edge.
    task automatic run_op(input logic signed [15:0] va, input logic signed [15:0] vb, input string tag);
        int exp = model(va, vb);
        @(negedge clk);
        a = va; b = vb; start = 1'b1;
        @(negedge clk);
        start = 1'b0; a = 16'sh1234; b = -16'sh0777;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 5) begin
                check(done == 1'b1, {tag, " R4 done"}, done, 1);
                check(result == 17'(exp), {tag, " R2 value"}, result, exp);
            end else begin
                check(done == 1'b0, {tag, " R4 no done"}, done, 0);
                check(result == '0, {tag, " R5 zero"}, result, 0);
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 reset state", result, 0);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        run_op(16'sd0, 16'sd0, "zeros");
        run_op(16'sd100, 16'sd0, "one zero");
        run_op(16'sd0, -16'sd100, "other zero");
        run_op(16'sd300, -16'sd300, "equal opposite");
        run_op(16'sd3, 16'sd4, "small");
        run_op(16'sd7, 16'sd1, "truncation");
        run_op(16'sd1000, 16'sd2, "tiny y");
    endtask

    task automatic t_symmetry();
        run_op(-16'sd1234, 16'sd567, "R9 base");
        run_op(16'sd567, -16'sd1234, "R9 swapped");
        run_op(16'sd1234, -16'sd567, "R9 negated");
    endtask

    task automatic t_extremes();
        run_op(-16'sd32768, -16'sd32768, "R3 both min");
        run_op(-16'sd32768, 16'sd0, "R3 min zero");
        run_op(16'sd32767, -16'sd32768, "R3 max min");
        run_op(16'sd32767, 16'sd32767, "R8 both max");
    endtask

    // R6: a fresh start with other operands while busy must not disturb the operation
    task automatic t_busy_start();
        int exp = model(16'sd900, 16'sd400);
        @(negedge clk);
        a = 16'sd900; b = 16'sd400; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 2) begin start = 1'b1; a = -16'sd5; b = 16'sd20000; end
            if (k == 4) start = 1'b0;
            if (k == 5) begin
                check(done == 1'b1, "R6 done", done, 1);
                check(result == 17'(exp), "R6 value kept", result, exp);
            end else begin
                check(done == 1'b0, "R6 no extra done", done, 0);
            end
        end
    endtask

    // R7: start held high issues one operation every seven cycles
    task automatic t_back_to_back();
        int e1 = model(16'sd5000, -16'sd3000);
        int e2 = model(-16'sd12, 16'sd8);
        @(negedge clk);
        a = 16'sd5000; b = -16'sd3000; start = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 1) begin a = -16'sd12; b = 16'sd8; end
            if (k == 7) begin start = 1'b0; a = 16'sd1; b = 16'sd1; end
            if (k == 5) begin
                check(done == 1'b1, "R7 first done", done, 1);
                check(result == 17'(e1), "R7 first value", result, e1);
            end else if (k == 12) begin
                check(done == 1'b1, "R7 second done", done, 1);
                check(result == 17'(e2), "R7 second value", result, e2);
            end else begin
                check(done == 1'b0, "R7 gap", done, 0);
            end
        end
        repeat (9) begin
            @(negedge clk);
            check(done == 1'b0, "R7 idle after", done, 0);
        end
    endtask

    // R1: reset in the middle of an operation abandons it
    task automatic t_reset_mid();
        @(negedge clk);
        a = 16'sd777; b = 16'sd333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(done == 1'b0 && result == '0, "R1 abandoned", result, 0);
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_symmetry();
        t_extremes();
        t_busy_start();
        t_back_to_back();
        t_reset_mid();
        run_op(16'sd42, -16'sd17, "after reset");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

endmodule